// File: doc/BRIEF.md
# ADC Threshold Interrupt Monitor

This block is the control and status register for a 10-bit converter result stream. Each time a conversion finishes, the eight most significant result bits are compared against a programmable upper limit and a programmable lower limit. A comparator that fires sets its own sticky status flag. The two flags are ORed onto one active-low interrupt line for an 8-bit microcontroller.

Software reads the status bits to find which limit caused the interrupt. It clears each flag on its own by writing a one to the matching clear bit. A mode bit swaps the sense of both comparisons, so the block can report a result that has come back inside a window rather than one that has left it. Three more control bits (reference select, continuous conversion, manual start) are stored and driven out to the converter logic. The converter itself lies outside this block.

Top module: `adc_thresh_mon`

## Requirements
- R1: After reset every register reads 0x00, the mode outputs are 0 and `irq_n` is high.
- R2: Address 0 is the control register. A write stores wdata[3:0] in bits 3:0 (bit 3 inverted mode, bit 2 reference select, bit 1 continuous conversion, bit 0 manual start), and those bits read back and appear on the matching outputs.
- R3: Address 1 (upper limit) and address 2 (lower limit) are 8-bit read/write registers. Address 3 reads 0x00 and writes to it have no effect.
- R4: In normal mode (control bit 3 = 0), a cycle with `conv_done` high sets the high flag (control bit 6) when conv_data[9:2] > upper limit. It sets the low flag (control bit 4) when conv_data[9:2] < lower limit.
- R5: In inverted mode (control bit 3 = 1), `conv_done` sets the high flag when conv_data[9:2] <= upper limit. It sets the low flag when conv_data[9:2] >= lower limit.
- R6: A set flag stays set until it is cleared. A write to address 0 cannot set bit 6 or bit 4.
- R7: Writing 1 to control bit 7 clears bit 6, and writing 1 to bit 5 clears bit 4. Each clear leaves the other flag alone. Bits 7 and 5 always read 0.
- R8: If a setting conversion and the clear of the same flag fall in the same cycle, the flag ends up set.
- R9: `irq_n` is low exactly while either flag is set. It falls in the cycle after the `conv_done` that sets a flag.
- R10: While `conv_done` is low, `conv_data` has no effect on either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select: 0 control, 1 upper limit, 2 lower limit |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| conv_done | input | 1 | One-cycle end-of-conversion strobe |
| conv_data | input | 10 | Conversion result |
| mode_inv | output | 1 | Inverted comparison mode |
| ref_sel | output | 1 | Reference select |
| cont_en | output | 1 | Continuous conversion enable |
| man_start | output | 1 | Manual start |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The main sweep feeds all 256 values of the compared upper byte, each with a different pair of discarded low bits. It does this in both modes and against three limit pairs: a mid-range pair, limits at 0x00/0xFF and a pair with equal limits. Values one below, equal to and one above each limit therefore show whether the comparison is strict or inclusive, and whether the two low bits leak into the decision. Further directed cases set a flag in the same cycle it is cleared, clear one flag while the other stays set, try to set the status bits by writing them, and move `conv_data` with no strobe. Together these separate the set-priority rule, the independence of the two flags and the rule that only a strobed result counts.

// File: rtl/adc_thm_pkg.sv
package adc_thm_pkg;

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_LIM_HI = 2'd1,
        ADDR_LIM_LO = 2'd2,
        ADDR_SPARE  = 2'd3
    } reg_addr_e;

    // control register bit positions (software decodes these)
    localparam int CB_HI_CLR = 7;
    localparam int CB_HI_ST  = 6;
    localparam int CB_LO_CLR = 5;
    localparam int CB_LO_ST  = 4;
    localparam int CB_INV    = 3;
    localparam int CB_REF    = 2;
    localparam int CB_CONT   = 1;
    localparam int CB_START  = 0;

    typedef struct packed {
        logic [3:0]       mode;
        logic [REG_W-1:0] lim_hi;
        logic [REG_W-1:0] lim_lo;
        logic             hi_flag;
        logic             lo_flag;
    } thm_state_t;

endpackage

// File: rtl/adc_thm_cmp.sv
module adc_thm_cmp #(
    parameter int RES_W = 10,
    parameter int CMP_W = 8
) (
    input  logic [RES_W-1:0] result,
    input  logic [CMP_W-1:0] lim_hi,
    input  logic [CMP_W-1:0] lim_lo,
    input  logic             inv,
    output logic             hi_hit,
    output logic             lo_hit
);
    localparam int DROP = RES_W - CMP_W;

    // Extend each limit to full result width: compare on the top CMP_W
    // bits is equivalent to comparing the full value against the limit
    // padded with ones (for "above") or zeros (for "below").
    logic [RES_W-1:0] hi_top;
    logic [RES_W-1:0] lo_bot;

    generate
        if (DROP > 0) begin : g_pad
            assign hi_top = {lim_hi, {DROP{1'b1}}};
            assign lo_bot = {lim_lo, {DROP{1'b0}}};
        end else begin : g_nopad
            assign hi_top = lim_hi;
            assign lo_bot = lim_lo;
        end
    endgenerate

    logic above_hi;
    logic below_lo;

    always_comb begin
        above_hi = result > hi_top;
        below_lo = result < lo_bot;
        if (inv) begin
            hi_hit = !above_hi;
            lo_hit = !below_lo;
        end else begin
            hi_hit = above_hi;
            lo_hit = below_lo;
        end
    end

endmodule

// File: rtl/adc_thm_regs.sv
module adc_thm_regs
    import adc_thm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             conv_done,
    input  logic             hi_hit,
    input  logic             lo_hit,
    output logic [3:0]       mode,
    output logic [REG_W-1:0] lim_hi,
    output logic [REG_W-1:0] lim_lo,
    output logic             hi_flag,
    output logic             lo_flag
);
    thm_state_t s_d, s_q;

    logic ctrl_wr_d;
    logic clr_hi_d;
    logic clr_lo_d;
    logic set_hi_d;
    logic set_lo_d;

    always_comb begin
        s_d       = s_q;
        ctrl_wr_d = reg_wr && (reg_addr == ADDR_CTRL);
        clr_hi_d  = ctrl_wr_d && reg_wdata[CB_HI_CLR];
        clr_lo_d  = ctrl_wr_d && reg_wdata[CB_LO_CLR];
        set_hi_d  = conv_done && hi_hit;
        set_lo_d  = conv_done && lo_hit;

        if (ctrl_wr_d) begin
            s_d.mode = reg_wdata[3:0];
        end
        if (reg_wr && (reg_addr == ADDR_LIM_HI)) begin
            s_d.lim_hi = reg_wdata;
        end
        if (reg_wr && (reg_addr == ADDR_LIM_LO)) begin
            s_d.lim_lo = reg_wdata;
        end

        // a setting event outranks a clear in the same cycle
        s_d.hi_flag = set_hi_d || (s_q.hi_flag && !clr_hi_d);
        s_d.lo_flag = set_lo_d || (s_q.lo_flag && !clr_lo_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[3:0]      = s_q.mode;
                reg_rdata[CB_HI_ST] = s_q.hi_flag;
                reg_rdata[CB_LO_ST] = s_q.lo_flag;
            end
            ADDR_LIM_HI: reg_rdata = s_q.lim_hi;
            ADDR_LIM_LO: reg_rdata = s_q.lim_lo;
            default:     reg_rdata = '0;
        endcase
    end

    assign mode    = s_q.mode;
    assign lim_hi  = s_q.lim_hi;
    assign lim_lo  = s_q.lim_lo;
    assign hi_flag = s_q.hi_flag;
    assign lo_flag = s_q.lo_flag;

endmodule

// File: rtl/adc_thresh_mon.sv
module adc_thresh_mon
    import adc_thm_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             mode_inv,
    output logic             ref_sel,
    output logic             cont_en,
    output logic             man_start,
    output logic             irq_n
);
    logic [3:0]       mode;
    logic [REG_W-1:0] lim_hi;
    logic [REG_W-1:0] lim_lo;
    logic             hi_hit;
    logic             lo_hit;
    logic             hi_flag;
    logic             lo_flag;

    adc_thm_cmp #(
        .RES_W(RES_W),
        .CMP_W(REG_W)
    ) cmp_i (
        .result (conv_data),
        .lim_hi (lim_hi),
        .lim_lo (lim_lo),
        .inv    (mode[CB_INV]),
        .hi_hit (hi_hit),
        .lo_hit (lo_hit)
    );

    adc_thm_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .conv_done (conv_done),
        .hi_hit    (hi_hit),
        .lo_hit    (lo_hit),
        .mode      (mode),
        .lim_hi    (lim_hi),
        .lim_lo    (lim_lo),
        .hi_flag   (hi_flag),
        .lo_flag   (lo_flag)
    );

    assign mode_inv  = mode[CB_INV];
    assign ref_sel   = mode[CB_REF];
    assign cont_en   = mode[CB_CONT];
    assign man_start = mode[CB_START];
    assign irq_n     = !(hi_flag || lo_flag);

endmodule

// File: rtl/adc_thm_chk.sv
module adc_thm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_addr,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       conv_done,
    input logic       hi_flag,
    input logic       lo_flag,
    input logic       irq_n
);
    // R4 R5 R10: a flag only rises after a conversion strobe
    assert_hi_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_flag) |-> $past(conv_done));
    assert_lo_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_flag) |-> $past(conv_done));

    // R7: clear without a competing event empties the flag
    assert_hi_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[7] && !conv_done) |=> !hi_flag);
    assert_lo_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[5] && !conv_done) |=> !lo_flag);

    // R6: sticky without a clear
    assert_hi_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_flag && !(reg_wr && reg_addr == 2'd0 && reg_wdata[7])) |=> hi_flag);
    assert_lo_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_flag && !(reg_wr && reg_addr == 2'd0 && reg_wdata[5])) |=> lo_flag);

    // R9: interrupt falls only after a strobe
    assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(conv_done));

    // R7: clear bits never read back
    assert_clear_bits_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[7] == 1'b0 && reg_rdata[5] == 1'b0));

endmodule

bind adc_thresh_mon adc_thm_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .conv_done (conv_done),
    .hi_flag   (hi_flag),
    .lo_flag   (lo_flag),
    .irq_n     (irq_n)
);

// File: tb/adc_thresh_mon_tb_top.sv
module adc_thresh_mon_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic       mode_inv, ref_sel, cont_en, man_start, irq_n;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    adc_thresh_mon dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .mode_inv  (mode_inv),
        .ref_sel   (ref_sel),
        .cont_en   (cont_en),
        .man_start (man_start),
        .irq_n     (irq_n)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // inputs change on the falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic conv(input logic [9:0] v);
        @(negedge clk);
        conv_data = v; conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    function automatic logic [7:0] ctrl_exp(input logic h, input logic l, input logic [3:0] m);
        return {1'b0, h, 1'b0, l, m};
    endfunction

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] his [3];
        logic [7:0] los [3];
        his[0] = 8'h80; los[0] = 8'h40;
        his[1] = 8'hFF; los[1] = 8'h00;
        his[2] = 8'h55; los[2] = 8'h55;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(2'd0, r); check("R1 ctrl", r, 0);
        rd(2'd1, r); check("R1 lim_hi", r, 0);
        rd(2'd2, r); check("R1 lim_lo", r, 0);
        check("R1 irq_n", irq_n, 1);
        check("R1 outs", {mode_inv, ref_sel, cont_en, man_start}, 0);

        // R2: control mode bits
        wr(2'd0, 8'h0F);
        rd(2'd0, r); check("R2 ctrl rb", r, 8'h0F);
        check("R2 outs", {mode_inv, ref_sel, cont_en, man_start}, 4'hF);
        wr(2'd0, 8'h06);
        rd(2'd0, r); check("R2 ctrl rb2", r, 8'h06);
        check("R2 outs2", {mode_inv, ref_sel, cont_en, man_start}, 4'h6);

        // R3: limits and spare address
        wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
        rd(2'd1, r); check("R3 lim_hi", r, 8'hA5);
        rd(2'd2, r); check("R3 lim_lo", r, 8'h3C);
        wr(2'd3, 8'hFF);
        rd(2'd3, r); check("R3 spare", r, 0);
        rd(2'd1, r); check("R3 spare no effect hi", r, 8'hA5);
        rd(2'd2, r); check("R3 spare no effect lo", r, 8'h3C);
        rd(2'd0, r); check("R3 spare no effect ctrl", r, 8'h06);

        // R6: writing status bits cannot set them
        wr(2'd0, 8'h50);
        rd(2'd0, r); check("R6 status not writable", r, 8'h00);
        check("R6 irq", irq_n, 1);

        // R4/R5: sweep every upper byte in both modes, three limit pairs
        for (int p = 0; p < 3; p++) begin
            wr(2'd1, his[p]); wr(2'd2, los[p]);
            for (int m = 0; m < 2; m++) begin
                for (int u = 0; u < 256; u++) begin
                    logic eh, el;
                    wr(2'd0, 8'hA0 | 8'(m << 3));
                    conv({u[7:0], u[1:0] ^ 2'(m)});
                    if (m == 0) begin
                        eh = (u > his[p]); el = (u < los[p]);
                    end else begin
                        eh = (u <= his[p]); el = (u >= los[p]);
                    end
                    rd(2'd0, r);
                    check(m ? "R5 flags" : "R4 flags", r, ctrl_exp(eh, el, 4'(m << 3)));
                    check("R9 irq level", irq_n, !(eh || el));
                end
            end
        end

        // R8, R7, R9, R10 directed: limits hi=0x80 lo=0x40, normal mode
        wr(2'd1, 8'h80); wr(2'd2, 8'h40);
        wr(2'd0, 8'hA0);
        conv(10'h3FF);                         // high flag only
        rd(2'd0, r); check("R4 hi only", r, 8'h40);
        conv(10'h000);                         // add low flag
        rd(2'd0, r); check("R6 both sticky", r, 8'h50);
        wr(2'd0, 8'h20);                       // clear low only
        rd(2'd0, r); check("R7 clear lo keeps hi", r, 8'h40);
        check("R9 irq still low", irq_n, 0);
        wr(2'd0, 8'h80);
        rd(2'd0, r); check("R7 clear hi", r, 8'h00);
        check("R9 irq released", irq_n, 1);

        // R8: set and clear of high flag in the same cycle
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = 8'h80; reg_wr = 1'b1;
        conv_data = 10'h3FF; conv_done = 1'b1;
        #1 check("R9 irq before edge", irq_n, 1);
        @(negedge clk);
        reg_wr = 1'b0; conv_done = 1'b0;
        #1 check("R9 irq after edge", irq_n, 0);
        rd(2'd0, r); check("R8 set wins", r, 8'h40);
        wr(2'd0, 8'hA0);

        // R10: data moves without strobe
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            conv_data = (k[0]) ? 10'h3FF : 10'h000;
        end
        rd(2'd0, r); check("R10 no strobe", r, 8'h00);
        check("R10 irq", irq_n, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule